// File: doc/BRIEF.md
# Serial 0-1-0 pattern detector with table-driven next-state logic

This block watches a one-bit serial stream, one bit per clock, and raises a detect flag when the current bit completes the pattern 0, 1, 0. It is a Mealy machine, so the flag belongs to the bit presented in the same cycle. Matches may overlap: the final 0 of one match can be the first 0 of the next, so the stream 0,1,0,1,0 gives two detects.

The machine holds its state in two flip-flops. All next-state and output logic sits in three small lookup tables, one per flip-flop D input and one for the detect flag. Each table is addressed by the current state bits followed by the input bit. The table contents are computed at elaboration from the transition rules, not written out by hand.

Top module: `seq010_detector`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, the machine is idle: detect_o is 0 whatever the value of bit_i.
- R2: From idle, a 1 keeps the machine idle and a 0 moves it to the "seen 0" state. detect_o stays 0 in both cases, so runs of 1s never produce a detect.
- R3: From "seen 0", further 0s keep it there and a 1 moves it to "seen 0 1". detect_o is 0 in both cases, so 0,0,1,0 detects on its final bit.
- R4: From "seen 0 1", a 0 asserts detect_o and returns to "seen 0", which allows overlapping matches: 0,1,0,1,0 detects on its third and fifth bits.
- R5: From "seen 0 1", a 1 returns the machine to idle with detect_o 0, so 0,1,1,0 produces no detect.
- R6: detect_o is combinational from bit_i in the current cycle. With the state at "seen 0 1", changing bit_i between clock edges changes detect_o at once (1 for bit_i=0, 0 for bit_i=1).
- R7: For any input stream after reset, detect_o equals 1 exactly when the current bit and the two bits before it, all received since reset, are 0,1,0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Serial input bit, one per cycle |
| detect_o | output | 1 | High when bit_i completes 0,1,0 |

## Verification
The hard case is a chain of overlapping matches. It needs the machine to leave "seen 0 1" on a 0 and then climb back through a 1 with no reset between. An exhaustive sweep over every 12-bit stream after a reset covers every such chain up to that length. It also covers every path through the idle and "seen 0" self-loops. A long random stream afterwards tests the same history model over thousands of cycles without a reset.

// File: rtl/seq010_pkg.sv
package seq010_pkg;
  localparam int STATE_W = 2;
  localparam int ADDR_W  = STATE_W + 1;
  localparam int ROW_W   = STATE_W + 1;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE  = 2'b00,
    ST_GOT01 = 2'b01,
    ST_GOT0  = 2'b10,
    ST_SPARE = 2'b11
  } st_e;

  // row = {d1, d0, det}; addr = {q1, q0, bit}
  function automatic logic [ROW_W-1:0] table_row(input logic [ADDR_W-1:0] addr);
    logic [STATE_W-1:0] cur;
    logic               b;
    logic [STATE_W-1:0] nxt;
    logic               det;
    cur = addr[ADDR_W-1:1];
    b   = addr[0];
    det = 1'b0;
    if (!b) begin
      nxt = ST_GOT0;
      det = (cur == ST_GOT01);
    end else if (cur == ST_GOT0 || cur == ST_SPARE) begin
      nxt = ST_GOT01;  // spare code acts as "seen 0"
    end else begin
      nxt = ST_IDLE;
    end
    return {nxt, det};
  endfunction

  function automatic logic table_bit(input int col, input logic [ADDR_W-1:0] addr);
    logic [ROW_W-1:0] row;
    row = table_row(addr);
    return row[col];
  endfunction
endpackage

// File: rtl/seq010_rom.sv
module seq010_rom
  import seq010_pkg::*;
#(
  parameter int COL = 0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0] rom;

  for (genvar a = 0; a < DEPTH; a++) begin : g_row
    assign rom[a] = table_bit(COL, ADDR_W'(a));
  end

  assign data_o = rom[addr_i];
endmodule

// File: rtl/seq010_state.sv
module seq010_state
  import seq010_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [STATE_W-1:0] d_i,
  output logic [STATE_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= ST_IDLE;
    else         q_o <= d_i;
  end

  p_reset_idle_r1: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> q_o == ST_IDLE);
endmodule

// File: rtl/seq010_detector.sv
module seq010_detector
  import seq010_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  output logic detect_o
);
  logic [STATE_W-1:0] state_q;
  logic [STATE_W-1:0] state_d;
  logic [ADDR_W-1:0]  addr;
  logic [ROW_W-1:0]   row;

  assign addr = {state_q, bit_i};

  for (genvar c = 0; c < ROW_W; c++) begin : g_tbl
    seq010_rom #(.COL(c)) u_rom (
      .addr_i (addr),
      .data_o (row[c])
    );
  end

  assign state_d  = row[ROW_W-1:1];
  assign detect_o = row[0];

  seq010_state u_state (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (state_d),
    .q_o    (state_q)
  );

  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_IDLE |-> !detect_o);
  p_idle_one_stays_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && bit_i) |=> state_q == ST_IDLE);
  p_got0_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_GOT0 |-> !detect_o);
  p_zero_to_got0_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_i |=> state_q == ST_GOT0);
  p_match_detect_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_GOT01 && !bit_i) |-> detect_o);
  p_break_to_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_GOT01 && bit_i) |=> (state_q == ST_IDLE && !$past(detect_o)));
  p_legal_code_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != ST_SPARE);
endmodule

// File: tb/seq010_detector_bench.sv
`timescale 1ns/1ps
module seq010_detector_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_in = 1'b0;
  logic det;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [1:0] hist;
  int         seen;

  always #2.5 clk = ~clk;

  seq010_detector u_seq010_detector (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .bit_i    (bit_in),
    .detect_o (det)
  );

  task automatic check(input logic exp, input string req);
    checks++;
    if (det !== exp) begin
      failures++;
      $display("FAIL %s: detect_o=%b expected=%b", req, det, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    bit_in = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    hist = 2'b00;
    seen = 0;
  endtask

  // drive one bit at negedge, check model, let posedge advance
  task automatic step(input logic b, input string req);
    logic exp;
    bit_in = b;
    #1;
    exp = (seen >= 2) && (hist == 2'b01) && !b;
    check(exp, req);
    @(negedge clk);
    hist = {hist[0], b};
    if (seen < 2) seen++;
  endtask

  task automatic seq(input logic [15:0] bits, input int n, input string req);
    for (int i = n - 1; i >= 0; i--) step(bits[i], req);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    // R1: during reset and first cycle after release
    @(negedge clk);
    bit_in = 1'b1; #1; check(1'b0, "R1 in reset bit=1");
    bit_in = 1'b0; #1; check(1'b0, "R1 in reset bit=0");
    do_reset();
    step(1'b0, "R1 first cycle bit=0");
    do_reset();
    step(1'b1, "R1 first cycle bit=1");

    // R2: runs of ones then a 0 from idle
    do_reset();
    seq(16'b11110, 5, "R2");
    // R3: 0,0,1,0
    do_reset();
    seq(16'b0010, 4, "R3");
    // R4: overlap 0,1,0,1,0
    do_reset();
    seq(16'b01010, 5, "R4");
    // R5: 0,1,1,0
    do_reset();
    seq(16'b0110, 4, "R5");

    // R6: combinational response within one cycle
    do_reset();
    seq(16'b01, 2, "R6 setup");
    bit_in = 1'b1; #1; check(1'b0, "R6 bit=1");
    bit_in = 1'b0; #1; check(1'b1, "R6 bit=0");
    bit_in = 1'b1; #0.5; check(1'b0, "R6 bit=1 again");

    // R7: exhaustive 12-bit streams after reset
    for (int v = 0; v < 4096; v++) begin
      do_reset();
      seq(16'(v), 12, "R7 sweep");
    end

    // R7: long random stream without reset
    do_reset();
    lfsr = 32'hACE1_2468;
    for (int i = 0; i < 5000; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step(lfsr[0], "R7 random");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule